// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of one line of a write-back cache that sits on a shared snooping bus. The line has four states: Invalid, Shared, Exclusive and Modified. Each state has its own rules for when the processor may read or write locally and when the controller must first use the bus. The line holds one address tag and one data word.

On the processor side, a request is a read, a write or an eviction, and it is held until done. A request that needs the bus raises a bus request with a command and stalls until the grant arrives. The shared vote from the other caches is sampled in the grant cycle of a line read, and that vote decides whether the line lands in Exclusive or in Shared. In Exclusive the line can be written with no bus traffic at all.

On the snoop side, the controller watches the other masters' line reads and read-for-ownership commands. For a line it holds, it raises its contribution to the wired-OR shared line. A Modified copy flushes its word. A read-for-ownership invalidates the copy.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid. A snooped line read (snp_cmd 1) raises neither shared_out nor flush_req, and bus_req is low while no request is presented.
- R2: A read miss raises bus_req with bus_cmd 1 (line read) and holds cpu_stall high, with cpu_done low, until bus_gnt. In the grant cycle cpu_done is high and cpu_rdata equals bus_rdata. The line then enters Exclusive when shared_in was low in that cycle, and Shared when it was high.
- R3: A read whose address matches a line in Shared, Exclusive or Modified, and a write that matches a line in Modified, give cpu_hit and cpu_done in the same cycle with bus_req low. A later read hit returns the last word written.
- R4: A write that hits a line in Exclusive completes in one cycle with no bus request, and the line becomes Modified.
- R5: A write to a line in Shared, or a write miss, raises bus_req with bus_cmd 2 (read-for-ownership). On grant it completes, and the line becomes Modified holding the written word.
- R6: A snooped line read (snp_cmd 1) whose address matches a valid line raises shared_out in the same cycle. An Exclusive line then moves to Shared. A Modified line raises flush_req with flush_data set to its word, and then moves to Shared.
- R7: A snooped read-for-ownership (snp_cmd 2) that matches a valid line makes the line Invalid, flushing first when the line is Modified. A snoop to another address leaves the line unchanged.
- R8: flush_req is raised only by a Modified line, so a snooped Shared or Exclusive line never flushes.
- R9: An eviction (cpu_op 2) from Shared or Exclusive completes in one cycle with no bus request and leaves the line Invalid. An eviction from Modified raises bus_cmd 3 (write-back) with the line's tag on bus_addr and its word on bus_wdata, completes on grant, and leaves the line Invalid.
- R10: A read or write miss while the line is Modified under another tag first issues the write-back and does not complete on that grant. In the following cycle it issues the fill command for the new address.
- R11: When a snoop matches the line in the same cycle as a processor request, the processor request stalls for that cycle and raises no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request valid, held until done |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_addr | input | TAG_W | Request line address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_hit | output | 1 | Request served locally from the line |
| cpu_stall | output | 1 | Request pending |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 1 line read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | TAG_W | Address of the bus command |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Bus grant |
| bus_rdata | input | DATA_W | Fill word, valid in the grant cycle |
| shared_in | input | 1 | Sampled wired-OR shared line |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | TAG_W | Snooped address |
| shared_out | output | 1 | This cache's vote on the shared line |
| flush_req | output | 1 | Flush of the Modified word |
| flush_data | output | DATA_W | Flushed word |

## Verification
The bench builds the block with its default widths: a 32-bit word and an 8-bit tag. The tags it uses differ in only a few low bits, so a wrong tag compare shows up as a false hit or a missed snoop. The bench cannot read the line state directly, so it reads it back through the ports. A snooped line read tells Invalid (no vote) from valid, and it marks Modified by the flush. A following write tells Exclusive (silent) from Shared (read-for-ownership). The bench also delays grants by several cycles, to show that the request is held. It puts a snoop and a processor request in the same cycle, and it sends a miss on top of a dirty line of another tag.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_RSV = 2'd3} cpu_op_t;

  // State a fill lands in, from the shared vote seen at grant.
  function automatic line_st_t fill_state(input logic for_write, input logic shared_vote);
    if (for_write) return LN_M;
    return shared_vote ? LN_S : LN_E;
  endfunction

  // State after a matching snoop.
  function automatic line_st_t snoop_next(input line_st_t cur, input logic [1:0] cmd);
    if (cmd == BC_RDX) return LN_I;
    if (cmd == BC_RD && cur != LN_I) return LN_S;
    return cur;
  endfunction

  // Local processor hit rule.
  function automatic logic local_hit(input line_st_t cur, input logic [1:0] op, input logic match);
    if (!match) return 1'b0;
    if (op == OP_RD) return cur != LN_I;
    if (op == OP_WR) return cur == LN_M || cur == LN_E;
    return 1'b0;
  endfunction
endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_addr,
  input  line_st_t          st,
  input  logic [TAG_W-1:0]  tag,
  input  logic [DATA_W-1:0] data,
  output logic              snp_hit,
  output logic              shared_out,
  output logic              flush_req,
  output logic [DATA_W-1:0] flush_data,
  output line_st_t          snp_next_st
);
  logic is_coh_cmd;

  always_comb begin
    is_coh_cmd  = (snp_cmd == BC_RD) || (snp_cmd == BC_RDX);
    snp_hit     = snp_valid && is_coh_cmd && (st != LN_I) && (snp_addr == tag);
    shared_out  = snp_hit && (snp_cmd == BC_RD);
    flush_req   = snp_hit && (st == LN_M);
    flush_data  = flush_req ? data : '0;
    snp_next_st = snp_hit ? snoop_next(st, snp_cmd) : st;
  end
endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [1:0]       cpu_op,
  input  logic [TAG_W-1:0] cpu_addr,
  input  line_st_t         st,
  input  logic [TAG_W-1:0] tag,
  input  logic             snp_hit,
  input  logic             bus_gnt,
  output logic             cpu_hit,
  output logic             local_evict,
  output logic             victim_wb,
  output logic             need_bus,
  output logic [1:0]       cmd,
  output logic             done
);
  logic match;
  logic is_acc;

  always_comb begin
    match       = (st != LN_I) && (tag == cpu_addr);
    is_acc      = (cpu_op == OP_RD) || (cpu_op == OP_WR);
    cpu_hit     = cpu_req && !snp_hit && local_hit(st, cpu_op, match);
    local_evict = cpu_req && !snp_hit && (cpu_op == OP_EV) && (st != LN_M);
    victim_wb   = is_acc && (st == LN_M) && !match;
    need_bus    = cpu_req && !snp_hit && !cpu_hit && !local_evict && (is_acc || cpu_op == OP_EV);
    if (!need_bus)                              cmd = BC_NONE;
    else if (cpu_op == OP_EV || victim_wb)      cmd = BC_WB;
    else if (cpu_op == OP_RD)                   cmd = BC_RD;
    else                                        cmd = BC_RDX;
    done = cpu_hit || local_evict || (need_bus && bus_gnt && !victim_wb);
  end

  // A bus request is held until granted unless a snoop or a dropped request intervenes.
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (need_bus && !bus_gnt) |=> (need_bus || snp_hit || !cpu_req));

  assert_hit_nobus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cmd == BC_NONE));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [TAG_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [TAG_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_addr,
  output logic              shared_out,
  output logic              flush_req,
  output logic [DATA_W-1:0] flush_data
);
  line_st_t          st_q, st_d, snp_next_st;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              snp_hit, local_evict, victim_wb, need_bus, gnt_take;
  logic [1:0]        cmd;

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .st(st_q), .tag(tag_q), .data(data_q),
    .snp_hit(snp_hit), .shared_out(shared_out), .flush_req(flush_req),
    .flush_data(flush_data), .snp_next_st(snp_next_st)
  );

  mesi_cpu_unit #(.TAG_W(TAG_W)) u_cpu (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .st(st_q), .tag(tag_q), .snp_hit(snp_hit), .bus_gnt(bus_gnt),
    .cpu_hit(cpu_hit), .local_evict(local_evict), .victim_wb(victim_wb),
    .need_bus(need_bus), .cmd(cmd), .done(cpu_done)
  );

  always_comb begin
    gnt_take  = need_bus && bus_gnt;
    bus_req   = need_bus;
    bus_cmd   = cmd;
    bus_addr  = (cmd == BC_WB) ? tag_q : cpu_addr;
    bus_wdata = (cmd == BC_WB) ? data_q : '0;
    cpu_stall = cpu_req && !cpu_done;
    cpu_rdata = (gnt_take && cmd == BC_RD) ? bus_rdata : data_q;
  end

  // Snoop wins over the processor; the two never update in the same cycle.
  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    data_d = data_q;
    if (snp_hit) begin
      st_d = snp_next_st;
    end else if (cpu_hit && cpu_op == OP_WR) begin
      st_d   = LN_M;
      data_d = cpu_wdata;
    end else if (local_evict) begin
      st_d = LN_I;
    end else if (gnt_take) begin
      case (cmd)
        BC_WB:   st_d = LN_I;
        BC_RD: begin
          st_d   = fill_state(1'b0, shared_in);
          tag_d  = cpu_addr;
          data_d = bus_rdata;
        end
        BC_RDX: begin
          st_d   = fill_state(1'b1, shared_in);
          tag_d  = cpu_addr;
          data_d = cpu_wdata;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_I;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assert_fill_vote_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == BC_RD && !shared_in && !snp_hit) |=> (st_q == LN_E));

  assert_write_done_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_op == OP_WR) |=> (st_q == LN_M));

  assert_rdx_invalidates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_RDX && st_q != LN_I && snp_addr == tag_q) |=> (st_q == LN_I));

  assert_flush_leaves_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (st_q == LN_S || st_q == LN_I));

  assert_snoop_blocks_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_out || flush_req) |-> !cpu_done);
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int TAG_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic [TAG_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_hit, cpu_stall, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [TAG_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_gnt = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [TAG_W-1:0] snp_addr = '0;
  logic shared_out, flush_req;
  logic [DATA_W-1:0] flush_data;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .shared_in(shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .shared_out(shared_out), .flush_req(flush_req), .flush_data(flush_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cpu_req = 0; bus_gnt = 0; shared_in = 0; snp_valid = 0; snp_cmd = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_cpu(input logic [1:0] op, input logic [7:0] a, input logic [31:0] w);
    cpu_req = 1; cpu_op = op; cpu_addr = a; cpu_wdata = w;
  endtask

  // Snoop for one cycle; returns vote and flush seen.
  task automatic snoop(input logic [1:0] c, input logic [7:0] a, output logic sh, output logic fl, output logic [31:0] fd);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1; sh = shared_out; fl = flush_req; fd = flush_data;
    step(); idle();
  endtask

  // Read miss filled with given vote after given grant delay.
  task automatic read_fill(input string req, input logic [7:0] a, input logic sh, input logic [31:0] fw, input int delay);
    set_cpu(0, a, 0);
    for (int i = 0; i < delay; i++) begin
      #1;
      chk(req, "miss bus_req", bus_req, 1);
      chk(req, "miss cmd", bus_cmd, 1);
      chk(req, "miss stall", cpu_stall, 1);
      chk(req, "miss done", cpu_done, 0);
      step();
    end
    bus_gnt = 1; shared_in = sh; bus_rdata = fw;
    #1;
    chk(req, "fill done", cpu_done, 1);
    chk(req, "fill rdata", cpu_rdata, fw);
    step(); idle();
  endtask

  task automatic write_hit(input string req, input logic [7:0] a, input logic [31:0] w);
    set_cpu(1, a, w);
    #1;
    chk(req, "wr hit", cpu_hit, 1);
    chk(req, "wr done", cpu_done, 1);
    chk(req, "wr no bus", bus_req, 0);
    step(); idle();
  endtask

  task automatic write_rdx(input string req, input logic [7:0] a, input logic [31:0] w);
    set_cpu(1, a, w);
    #1;
    chk(req, "rdx req", bus_req, 1);
    chk(req, "rdx cmd", bus_cmd, 2);
    chk(req, "rdx stall", cpu_done, 0);
    step();
    bus_gnt = 1;
    #1;
    chk(req, "rdx done", cpu_done, 1);
    step(); idle();
  endtask

  task automatic read_hit(input string req, input logic [7:0] a, input logic [31:0] exp);
    set_cpu(0, a, 0);
    #1;
    chk(req, "rd hit", cpu_hit, 1);
    chk(req, "rd done", cpu_done, 1);
    chk(req, "rd data", cpu_rdata, exp);
    chk(req, "rd no bus", bus_req, 0);
    step(); idle();
  endtask

  task automatic t_reset();
    logic sh, fl; logic [31:0] fd;
    #1;
    chk("R1", "bus_req idle", bus_req, 0);
    chk("R1", "flush idle", flush_req, 0);
    snoop(1, 8'h05, sh, fl, fd);
    chk("R1", "vote after reset", sh, 0);
    chk("R1", "flush after reset", fl, 0);
  endtask

  task automatic t_exclusive_path();
    logic sh, fl; logic [31:0] fd;
    read_fill("R2", 8'h10, 0, 32'hAAAA_0001, 3);
    read_hit("R3", 8'h10, 32'hAAAA_0001);
    write_hit("R4", 8'h10, 32'h0000_BEEF);
    read_hit("R3", 8'h10, 32'h0000_BEEF);
    snoop(1, 8'h10, sh, fl, fd);
    chk("R6", "vote on M", sh, 1);
    chk("R6", "flush on M", fl, 1);
    chk("R6", "flush data", fd, 32'h0000_BEEF);
    snoop(1, 8'h10, sh, fl, fd);
    chk("R8", "vote on S", sh, 1);
    chk("R8", "no flush from S", fl, 0);
    write_rdx("R5", 8'h10, 32'h1234_5678);
    snoop(2, 8'h10, sh, fl, fd);
    chk("R7", "rdx flush from M", fl, 1);
    chk("R7", "rdx flush data", fd, 32'h1234_5678);
    snoop(1, 8'h10, sh, fl, fd);
    chk("R7", "invalid after rdx", sh, 0);
  endtask

  task automatic t_shared_fill_evict();
    logic sh, fl; logic [31:0] fd;
    read_fill("R2", 8'h20, 1, 32'h0000_1234, 0);
    write_rdx("R2", 8'h20, 32'hCAFE_0020);
    set_cpu(2, 8'h20, 0);
    #1;
    chk("R9", "wb cmd", bus_cmd, 3);
    chk("R9", "wb addr", bus_addr, 8'h20);
    chk("R9", "wb data", bus_wdata, 32'hCAFE_0020);
    chk("R9", "wb wait", cpu_done, 0);
    step();
    bus_gnt = 1;
    #1;
    chk("R9", "wb done", cpu_done, 1);
    step(); idle();
    snoop(1, 8'h20, sh, fl, fd);
    chk("R9", "invalid after wb", sh, 0);
    read_fill("R9", 8'h30, 0, 32'h3030, 1);
    set_cpu(2, 8'h30, 0);
    #1;
    chk("R9", "silent evict done", cpu_done, 1);
    chk("R9", "silent evict no bus", bus_req, 0);
    step(); idle();
    snoop(1, 8'h30, sh, fl, fd);
    chk("R9", "invalid after evict", sh, 0);
  endtask

  task automatic t_victim();
    read_fill("R10", 8'h40, 0, 32'h4040, 0);
    write_hit("R10", 8'h40, 32'hD00D_0040);
    set_cpu(0, 8'h41, 0);
    #1;
    chk("R10", "victim cmd", bus_cmd, 3);
    chk("R10", "victim addr", bus_addr, 8'h40);
    chk("R10", "victim data", bus_wdata, 32'hD00D_0040);
    step();
    bus_gnt = 1;
    #1;
    chk("R10", "no done on wb", cpu_done, 0);
    step();
    bus_gnt = 0;
    #1;
    chk("R10", "fill cmd", bus_cmd, 1);
    chk("R10", "fill addr", bus_addr, 8'h41);
    step();
    bus_gnt = 1; bus_rdata = 32'h4141;
    #1;
    chk("R10", "fill done", cpu_done, 1);
    chk("R10", "fill data", cpu_rdata, 32'h4141);
    step(); idle();
  endtask

  task automatic t_collision();
    logic sh, fl; logic [31:0] fd;
    set_cpu(0, 8'h41, 0);
    snp_valid = 1; snp_cmd = 1; snp_addr = 8'h41;
    #1;
    chk("R11", "stall on snoop", cpu_stall, 1);
    chk("R11", "no done on snoop", cpu_done, 0);
    chk("R11", "no bus on snoop", bus_req, 0);
    chk("R6", "vote on E", shared_out, 1);
    chk("R8", "no flush from E", flush_req, 0);
    step();
    snp_valid = 0;
    #1;
    chk("R11", "done after snoop", cpu_done, 1);
    step(); idle();
    snoop(2, 8'h99, sh, fl, fd);
    chk("R7", "other addr no vote", sh, 0);
    read_hit("R7", 8'h41, 32'h4141);
    write_rdx("R6", 8'h41, 32'h5151);
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_exclusive_path();
    t_shared_fill_evict();
    t_victim();
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule